// File: doc/BRIEF.md
# Prioritized CPU Interrupt Delivery Controller

This block stands between the external interrupt sources and one processor core. It captures three kinds of request: a reset request, a non-maskable request, and a maskable request that carries a 6-bit level. The core strobes `boundary` at every instruction boundary. When an evaluation is outstanding, the controller serves at most one pending request at that strobe, and it serves them in fixed priority order.

Reset and non-maskable requests both raise one combined exception pulse. A maskable request first copies its level into the interrupt-pending field of the cause register. It then raises the interrupt pulse only if the global enable bit and the mask field of the status register allow it. A request that is blocked is not dropped. It is evaluated again at each later boundary until it is delivered, replaced, or withdrawn. A level event of zero withdraws the request. The next evaluation then clears the pending field and raises no interrupt.

Top module: `irq_deliver`

## Requirements
- R1: The synchronous reset `rst` clears every pending request and the outstanding evaluation, and sets `cause_ip` to 0. After reset, a boundary raises no pulse until a new request event arrives.
- R2: An evaluation serves exactly one request, in this priority order: pending reset first, then pending non-maskable request, then pending maskable level. The two pulses are never high together.
- R3: A served reset or non-maskable request raises `exc_nmi_rst` and clears only its own flag. The evaluation then ends, so any request still pending waits for the next event on a request input.
- R4: A `lvl_evt` with `lvl_val` equal to 0 records a withdraw marker. The evaluation that serves the marker sets `cause_ip` to 0, raises no `exc_int`, and leaves the maskable side idle.
- R5: `cause_ip` changes only at the clock edge of a boundary that serves the maskable side. At that edge `cause_ip[k]` takes bit k of the pending level.
- R6: `exc_int` rises only when status bit 0 (global enable) is 1 and the pending level ANDed with status bits 15:10 is nonzero. The delivered level then stops being pending.
- R7: A maskable request that is disabled or masked stays pending and is evaluated again at every following boundary.
- R8: Any request event makes an evaluation outstanding for the next boundary after the event's cycle; an event in a boundary cycle affects only the following boundary. Without an outstanding evaluation, a boundary does nothing.
- R9: `exc_nmi_rst` and `exc_int` are high only in a cycle where `boundary` is high, one cycle per service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous controller reset, active high |
| rst_req | input | 1 | Reset request event, one cycle |
| nmi_req | input | 1 | Non-maskable request event, one cycle |
| lvl_evt | input | 1 | Maskable level event, one cycle |
| lvl_val | input | 6 | Level carried by `lvl_evt`; 0 withdraws |
| status_i | input | 32 | Status register: bit 0 enable, bits 15:10 mask |
| boundary | input | 1 | Instruction boundary strobe |
| cause_ip | output | 6 | Interrupt-pending field of the cause register |
| exc_nmi_rst | output | 1 | Combined reset/non-maskable exception pulse |
| exc_int | output | 1 | Maskable interrupt exception pulse |

## Verification
The assertions assume two things about the inputs. Request events and `boundary` are clean single-cycle or level values that are known at every clock edge. `rst` is held high from time zero until the first edge. The stimulus keeps within this. It drives every input at the falling edge, raises `rst` at start, gives each request as a one-cycle pulse, and changes `status_i` only between cycles. This keeps the interrupt-enable check, which compares with the status value of the previous cycle, well defined.

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int LVL_W  = 6,
  parameter int STAT_W = 32,
  parameter int IP_LSB = 10,
  parameter int IE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_req,
  input  logic              nmi_req,
  input  logic              lvl_evt,
  input  logic [LVL_W-1:0]  lvl_val,
  input  logic [STAT_W-1:0] status_i,
  input  logic              boundary,
  output logic [LVL_W-1:0]  cause_ip,
  output logic              exc_nmi_rst,
  output logic              exc_int
);
  localparam int IP_MSB = IP_LSB + LVL_W - 1;

  logic             pend_rst, pend_nmi, lvl_mark, armed;
  logic [LVL_W-1:0] pend_lvl, cause_q;

  wire             evt_any  = rst_req | nmi_req | lvl_evt;
  wire             eval     = boundary & armed;
  wire             take_rst = eval & pend_rst;
  wire             take_nmi = eval & ~pend_rst & pend_nmi;
  wire             take_lvl = eval & ~pend_rst & ~pend_nmi & (lvl_mark | (|pend_lvl));
  wire [LVL_W-1:0] imask    = status_i[IP_MSB:IP_LSB];
  wire             ien      = status_i[IE_BIT];
  wire             lvl_hit  = take_lvl & ~lvl_mark & ien & (|(pend_lvl & imask));
  wire             retry    = take_lvl & ~lvl_mark & ~lvl_hit;

  assign exc_nmi_rst = take_rst | take_nmi;
  assign exc_int     = lvl_hit;
  assign cause_ip    = cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rst <= 1'b0;
      pend_nmi <= 1'b0;
      lvl_mark <= 1'b0;
      pend_lvl <= '0;
      cause_q  <= '0;
      armed    <= 1'b0;
    end else begin
      pend_rst <= rst_req | (pend_rst & ~take_rst);
      pend_nmi <= nmi_req | (pend_nmi & ~take_nmi);
      if (lvl_evt) begin
        lvl_mark <= (lvl_val == '0);
        pend_lvl <= lvl_val;
      end else if (take_lvl) begin
        lvl_mark <= 1'b0;
        if (lvl_hit) pend_lvl <= '0;
      end
      if (take_lvl) cause_q <= lvl_mark ? '0 : pend_lvl;
      armed <= evt_any | (armed & ~(boundary & ~retry));
    end
  end
endmodule

module irq_deliver_chk #(
  parameter int LVL_W  = 6,
  parameter int STAT_W = 32,
  parameter int IP_LSB = 10,
  parameter int IE_BIT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [STAT_W-1:0] status_i,
  input logic              boundary,
  input logic [LVL_W-1:0]  cause_ip,
  input logic              exc_nmi_rst,
  input logic              exc_int
);
  localparam int IP_MSB = IP_LSB + LVL_W - 1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cause_ip == '0) && !exc_int && !exc_nmi_rst);

  assert_one_service_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_nmi_rst, exc_int}));

  assert_cause_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(cause_ip));

  assert_int_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    exc_int |-> status_i[IE_BIT]);

  assert_int_masked_R6: assert property (@(posedge clk) disable iff (rst)
    exc_int |=> (cause_ip & $past(status_i[IP_MSB:IP_LSB])) != '0);

  assert_pulse_on_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    (exc_int || exc_nmi_rst) |-> boundary);
endmodule

bind irq_deliver irq_deliver_chk #(
  .LVL_W(LVL_W), .STAT_W(STAT_W), .IP_LSB(IP_LSB), .IE_BIT(IE_BIT)
) chk_i (
  .clk(clk), .rst(rst), .status_i(status_i), .boundary(boundary),
  .cause_ip(cause_ip), .exc_nmi_rst(exc_nmi_rst), .exc_int(exc_int)
);

// File: tb/irq_deliver_tb.sv
module irq_deliver_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_req = 1'b0, nmi_req = 1'b0, lvl_evt = 1'b0, boundary = 1'b0;
  logic [5:0]  lvl_val = '0;
  logic [31:0] status_i = '0;
  logic [5:0]  cause_ip;
  logic        exc_nmi_rst, exc_int;
  int cmp = 0, mis = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_deliver dut_i (
    .clk(clk), .rst(rst), .rst_req(rst_req), .nmi_req(nmi_req),
    .lvl_evt(lvl_evt), .lvl_val(lvl_val), .status_i(status_i),
    .boundary(boundary), .cause_ip(cause_ip),
    .exc_nmi_rst(exc_nmi_rst), .exc_int(exc_int)
  );

  // row: ev[27:26] (0 none,1 rst,2 nmi,3 lvl), lv[25:20], ien[19], mask[18:13],
  //      bnd[12], exp_nmi_rst[11], exp_int[10], exp_cause[9:4], req[3:0]
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {2'd3, 6'd5,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd0,  4'd8}, // R8 no boundary, no eval
    {2'd0, 6'd0,  1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 6'd5,  4'd5}, // R5 cause mirrors level
    {2'd0, 6'd0,  1'b1, 6'd0,  1'b1, 1'b0, 1'b0, 6'd5,  4'd7}, // R7 masked, retried
    {2'd0, 6'd0,  1'b0, 6'd63, 1'b1, 1'b0, 1'b0, 6'd5,  4'd6}, // R6 enable off
    {2'd0, 6'd0,  1'b1, 6'd4,  1'b1, 1'b0, 1'b1, 6'd5,  4'd6}, // R6 delivered
    {2'd0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd5,  4'd8}, // R8 nothing armed
    {2'd3, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd5,  4'd4}, // R4 withdraw event
    {2'd0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0,  4'd4}, // R4 cause cleared
    {2'd0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0,  4'd4}, // R4 idle after marker
    {2'd2, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd0,  4'd2}, // R2 nmi pending
    {2'd1, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd0,  4'd2}, // R2 reset pending
    {2'd3, 6'd3,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd0,  4'd2}, // R2 level pending
    {2'd0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b1, 1'b0, 6'd0,  4'd2}, // R2 reset served first
    {2'd0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0,  4'd3}, // R3 evaluation ended
    {2'd3, 6'd2,  1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0,  4'd8}, // R8 event in boundary cycle
    {2'd0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b1, 1'b0, 6'd0,  4'd2}, // R2 nmi before level
    {2'd3, 6'd2,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd0,  4'd3}, // R3 new event re-arms
    {2'd0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b0, 1'b1, 6'd2,  4'd6}, // R6 level 2 delivered
    {2'd3, 6'd63, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd2,  4'd5}, // R5 cause held
    {2'd0, 6'd0,  1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 6'd63, 4'd5}, // R5 all six bits
    {2'd3, 6'd1,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd63, 4'd8}, // R8 replace level
    {2'd0, 6'd0,  1'b1, 6'd2,  1'b1, 1'b0, 1'b0, 6'd1,  4'd7}, // R7 mask mismatch
    {2'd0, 6'd0,  1'b1, 6'd2,  1'b1, 1'b0, 1'b0, 6'd1,  4'd7}, // R7 still retried
    {2'd0, 6'd0,  1'b1, 6'd1,  1'b1, 1'b0, 1'b1, 6'd1,  4'd6}  // R6 mask matches
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    cmp++;
    if (!ok) begin
      mis++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // drive at falling edge, check pulses before rise, cause after rise
  task automatic cyc(input logic [1:0] ev, input logic [5:0] lv, input logic ie,
                     input logic [5:0] mk, input logic bnd, input logic enr,
                     input logic ein, input logic [5:0] ec, input int rq);
    @(negedge clk);
    rst_req  = (ev == 2'd1);
    nmi_req  = (ev == 2'd2);
    lvl_evt  = (ev == 2'd3);
    lvl_val  = lv;
    status_i = {16'h0, mk, 9'h0, ie};
    boundary = bnd;
    #2;
    chk(exc_nmi_rst == enr, rq, "exc_nmi_rst", {7'd0, exc_nmi_rst}, {7'd0, enr});
    chk(exc_int == ein, rq, "exc_int", {7'd0, exc_int}, {7'd0, ein});
    @(posedge clk); #1;
    chk(cause_ip == ec, rq, "cause_ip", {2'd0, cause_ip}, {2'd0, ec});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      cmp++; mis++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state, boundary with nothing armed
    cyc(2'd0, 6'd0, 1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0, 1);
    for (int i = 0; i < NV; i++)
      cyc(VEC[i][27:26], VEC[i][25:20], VEC[i][19], VEC[i][18:13], VEC[i][12],
          VEC[i][11], VEC[i][10], VEC[i][9:4], int'(VEC[i][3:0]));
    // R1: reset while level, nmi and reset requests are pending
    cyc(2'd3, 6'd9, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd1, 8);
    cyc(2'd0, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 6'd9, 5);
    cyc(2'd2, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd9, 8);
    cyc(2'd1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd9, 8);
    @(negedge clk) begin rst = 1'b1; rst_req = 1'b0; nmi_req = 1'b0; end
    @(posedge clk); #1;
    chk(cause_ip == 6'd0, 1, "cause_ip after reset", {2'd0, cause_ip}, 8'd0);
    @(negedge clk) rst = 1'b0;
    cyc(2'd0, 6'd0, 1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0, 1);
    cyc(2'd0, 6'd0, 1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0, 1);
    // R9: pulse lasts one cycle, none with boundary low
    cyc(2'd2, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0, 9);
    cyc(2'd0, 6'd0, 1'b1, 6'd63, 1'b0, 1'b0, 1'b0, 6'd0, 9);
    cyc(2'd0, 6'd0, 1'b1, 6'd63, 1'b1, 1'b1, 1'b0, 6'd0, 9);
    cyc(2'd0, 6'd0, 1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 6'd0, 9);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  end
endmodule